// File: doc/BRIEF.md
# Period-Finding Semiprime Factor Extractor

This block takes an odd semiprime modulus and a trial base. It walks the powers of the base modulo the modulus until the sequence comes back to the base, which gives the period. When the period is even, it raises the base to half the period. It then runs two subtractive GCDs of the modulus against that half-power minus one and plus one. The results are two candidate factors and a status code. A host that gets an odd-period, trivial or timeout status retries with another base.

Multiplication is sequential. Each step doubles the running sum modulo the modulus and adds the multiplicand modulo the modulus, one bit of the multiplier per cycle, so the block needs no divider. Requests arrive on a valid/ready channel, and results leave on a second valid/ready channel. `in_ready` is high only while the block is idle. A result stays on the output, unchanged, until `out_ready` is seen high with `out_valid`. No new request is taken before that handshake. Any `in_valid` raised while the block is busy is ignored.

Top module: `period_factor_top`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A base with x <= 1 or x >= n is rejected. The result has status 3, period 0 and both factors 0, and it appears in the cycle after the request is accepted.
- R3: The reported period is the smallest i >= 1 for which x^(i+1) mod n equals x. For example, n=15 with x=7 gives 4, and n=15 with x=10 gives 1.
- R4: For an even period R, let y = x^(R/2) mod n. Then `out_fac_a` = GCD(y-1, n) and `out_fac_b` = GCD(y+1, n), where the GCD of 0 and n is n. For example, n=15 with x=7 gives 3 and 5.
- R5: An odd period gives status 1, with the period reported and both factors 0.
- R6: When both factors lie in {1, n}, the status is 2. For example, n=15 with x=14 gives 1 and 15.
- R7: When at least one factor lies strictly between 1 and n, the status is 0.
- R8: If no i from 1 to n-1 meets the R3 condition, the status is 4, and the period and both factors are 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, every result output holds its value. `in_ready` stays 0 from the accepting edge until the result handshake, and `in_valid` pulses in that span have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request accepted |
| in_n | input | W | Odd semiprime modulus |
| in_x | input | W | Trial base |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_status | output | 3 | 0 ok, 1 odd period, 2 trivial, 3 bad base, 4 timeout |
| out_period | output | W | Period found |
| out_fac_a | output | W | GCD(y-1, n) |
| out_fac_b | output | W | GCD(y+1, n) |

## Verification
A wrong modular product or a miscounted step changes the reported period. That error usually also flips the status between ok, odd period and trivial, and it appears at the port when the result is presented. A wrong half-power or a GCD that stops early shows up as wrong factors in that same result. A handshake fault appears within one cycle: either `in_ready` goes high while a result is pending, or the result changes under a stalled consumer. The bench checks for both of these on every clock.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [2:0] {
    ST_OK   = 3'd0,
    ST_ODD  = 3'd1,
    ST_TRIV = 3'd2,
    ST_BADX = 3'd3,
    ST_TMO  = 3'd4
  } pf_status_e;
endpackage

// File: rtl/pf_modmul.sv
// Sequential a*b mod m, one multiplier bit per cycle, MSB first.
module pf_modmul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic         done,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc, bsh, a_q, m_q, dbl_m, nxt;
  logic [W:0]    dbl, dbl_sub, sum, sum_sub;
  logic [CW-1:0] left;
  logic          busy;

  always_comb begin
    dbl     = {acc, 1'b0};
    dbl_sub = dbl - {1'b0, m_q};
    dbl_m   = (dbl >= {1'b0, m_q}) ? dbl_sub[W-1:0] : dbl[W-1:0];
    sum     = {1'b0, dbl_m} + {1'b0, a_q};
    sum_sub = sum - {1'b0, m_q};
    if (bsh[W-1]) nxt = (sum >= {1'b0, m_q}) ? sum_sub[W-1:0] : sum[W-1:0];
    else          nxt = dbl_m;
  end

  assign done = busy && (left == '0);
  assign res  = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      bsh  <= '0;
      a_q  <= '0;
      m_q  <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (go) begin
      acc  <= '0;
      bsh  <= b;
      a_q  <= a;
      m_q  <= m;
      left <= CW'(W);
      busy <= 1'b1;
    end else if (busy) begin
      if (left != '0) begin
        acc  <= nxt;
        bsh  <= bsh << 1;
        left <= left - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pf_gcd_sub.sv
// Subtractive GCD; a zero operand yields the other operand.
module pf_gcd_sub #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] res
);
  logic [W-1:0] ra, rb;
  logic         busy, fin;

  assign fin  = (ra == rb) || (ra == '0) || (rb == '0);
  assign done = busy && fin;
  assign res  = (ra == '0) ? rb : ra;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra   <= '0;
      rb   <= '0;
      busy <= 1'b0;
    end else if (go) begin
      ra   <= a;
      rb   <= b;
      busy <= 1'b1;
    end else if (busy) begin
      if (fin)          busy <= 1'b0;
      else if (ra > rb) ra   <= ra - rb;
      else              rb   <= rb - ra;
    end
  end
endmodule

// File: rtl/period_factor_top.sv
module period_factor_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_n,
  input  logic [W-1:0] in_x,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [2:0]   out_status,
  output logic [W-1:0] out_period,
  output logic [W-1:0] out_fac_a,
  output logic [W-1:0] out_fac_b
);
  import pf_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_POW_GO, S_POW_WAIT, S_HALF_CHK, S_HALF_WAIT,
    S_G1_GO, S_G1_WAIT, S_G2_GO, S_G2_WAIT, S_DONE
  } fsm_e;

  fsm_e         state;
  pf_status_e   status;
  logic [W-1:0] n_q, x_q, cur, cnt, per, fa, fb, half;
  logic         mul_go, mul_done, gcd_go, gcd_done;
  logic [W-1:0] prod, gcd_a, gres;
  logic         bad_base, nontriv_a, nontriv_b;

  assign half      = per >> 1;
  assign bad_base  = (in_x <= W'(1)) || (in_x >= in_n);
  assign mul_go    = (state == S_POW_GO) || (state == S_HALF_CHK && cnt != half);
  assign gcd_go    = (state == S_G1_GO) || (state == S_G2_GO);
  assign gcd_a     = (state == S_G2_GO) ? cur + 1'b1 : cur - 1'b1;
  assign nontriv_a = (fa > W'(1)) && (fa < n_q);
  assign nontriv_b = (gres > W'(1)) && (gres < n_q);

  pf_modmul #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .a(cur), .b(x_q), .m(n_q),
    .done(mul_done), .res(prod)
  );

  pf_gcd_sub #(.W(W)) u_gcd (
    .clk(clk), .rst_n(rst_n), .go(gcd_go), .a(gcd_a), .b(n_q),
    .done(gcd_done), .res(gres)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      status <= ST_OK;
      n_q    <= '0;
      x_q    <= '0;
      cur    <= '0;
      cnt    <= '0;
      per    <= '0;
      fa     <= '0;
      fb     <= '0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          n_q <= in_n;
          x_q <= in_x;
          cur <= in_x;
          cnt <= W'(1);
          per <= '0;
          fa  <= '0;
          fb  <= '0;
          if (bad_base) begin
            status <= ST_BADX;
            state  <= S_DONE;
          end else begin
            status <= ST_OK;
            state  <= S_POW_GO;
          end
        end
        S_POW_GO: state <= S_POW_WAIT;
        S_POW_WAIT: if (mul_done) begin
          if (prod == x_q) begin
            per <= cnt;
            if (cnt[0]) begin
              status <= ST_ODD;
              state  <= S_DONE;
            end else begin
              cur   <= x_q;
              cnt   <= W'(1);
              state <= S_HALF_CHK;
            end
          end else if ({1'b0, cnt} + 1'b1 >= {1'b0, n_q}) begin
            status <= ST_TMO;
            state  <= S_DONE;
          end else begin
            cur   <= prod;
            cnt   <= cnt + 1'b1;
            state <= S_POW_GO;
          end
        end
        S_HALF_CHK: state <= (cnt == half) ? S_G1_GO : S_HALF_WAIT;
        S_HALF_WAIT: if (mul_done) begin
          cur   <= prod;
          cnt   <= cnt + 1'b1;
          state <= S_HALF_CHK;
        end
        S_G1_GO: state <= S_G1_WAIT;
        S_G1_WAIT: if (gcd_done) begin
          fa    <= gres;
          state <= S_G2_GO;
        end
        S_G2_GO: state <= S_G2_WAIT;
        S_G2_WAIT: if (gcd_done) begin
          fb     <= gres;
          status <= (nontriv_a || nontriv_b) ? ST_OK : ST_TRIV;
          state  <= S_DONE;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready   = (state == S_IDLE);
  assign out_valid  = (state == S_DONE);
  assign out_status = status;
  assign out_period = per;
  assign out_fac_a  = fa;
  assign out_fac_b  = fb;
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_n,
  input logic [W-1:0] in_x,
  input logic         out_valid,
  input logic         out_ready,
  input logic [2:0]   out_status,
  input logic [W-1:0] out_period,
  input logic [W-1:0] out_fac_a,
  input logic [W-1:0] out_fac_b,
  input logic [W-1:0] n_q
);
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_status) &&
      $stable(out_period) && $stable(out_fac_a) && $stable(out_fac_b));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R2
  bad_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_x <= W'(1) || in_x >= in_n) |=>
      out_valid && out_status == 3'd3 && out_period == '0);

  // R5
  odd_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 3'd1 |->
      out_period[0] && out_fac_a == '0 && out_fac_b == '0);

  // R7
  ok_factor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 3'd0 |->
      (out_fac_a > W'(1) && out_fac_a < n_q) ||
      (out_fac_b > W'(1) && out_fac_b < n_q));

  // R8
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 3'd4 |-> out_period == '0);
endmodule

bind period_factor_top pf_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_n(in_n), .in_x(in_x), .out_valid(out_valid), .out_ready(out_ready),
  .out_status(out_status), .out_period(out_period), .out_fac_a(out_fac_a),
  .out_fac_b(out_fac_b), .n_q(n_q)
);

// File: tb/sim_period_factor_top.sv
`timescale 1ns/1ps
module sim_period_factor_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_n = '0;
  logic [W-1:0] in_x = '0;
  logic         in_ready, out_valid;
  logic [2:0]   out_status;
  logic [W-1:0] out_period, out_fac_a, out_fac_b;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  period_factor_top #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_n(in_n), .in_x(in_x), .out_valid(out_valid), .out_ready(out_ready),
    .out_status(out_status), .out_period(out_period),
    .out_fac_a(out_fac_a), .out_fac_b(out_fac_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gcd_ref(input int a, input int b);
    int p = a;
    int q = b;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  // Behavioural reference built from the requirements.
  task automatic model(input int n, input int x, output int st, output int r,
                       output int fa, output int fb);
    int y;
    st = 0; r = 0; fa = 0; fb = 0;
    if (x <= 1 || x >= n) begin st = 3; return; end
    y = x;
    for (int i = 1; i < n; i++) begin
      y = (y * x) % n;
      if (y == x) begin r = i; break; end
    end
    if (r == 0) begin st = 4; return; end
    if (r % 2 == 1) begin st = 1; return; end
    y = x;
    for (int i = 1; i < r / 2; i++) y = (y * x) % n;
    fa = gcd_ref(y - 1, n);
    fb = gcd_ref(y + 1, n);
    st = ((fa > 1 && fa < n) || (fb > 1 && fb < n)) ? 0 : 2;
  endtask

  function automatic string st_req(input int st);
    case (st)
      0: return "R7";
      1: return "R5";
      2: return "R6";
      3: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input int n, input int x, input int stall, input bit junk);
    int st, r, fa, fb;
    int s0, p0, a0, b0;
    model(n, x, st, r, fa, fb);
    @(negedge clk);
    in_n = W'(n);
    in_x = W'(x);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = junk;
    in_x = W'(x + 3);
    while (!out_valid) begin
      chk(in_ready == 1'b0, "R9 busy", int'(in_ready), 0);
      @(negedge clk);
    end
    s0 = int'(out_status); p0 = int'(out_period);
    a0 = int'(out_fac_a);  b0 = int'(out_fac_b);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(out_valid && int'(out_status) == s0 && int'(out_period) == p0 &&
          int'(out_fac_a) == a0 && int'(out_fac_b) == b0, "R9 hold",
          int'(out_period), p0);
    end
    chk(int'(out_status) == st, st_req(st), int'(out_status), st);
    chk(int'(out_period) == r, "R3", int'(out_period), r);
    chk(int'(out_fac_a) == fa, "R4 fac_a", int'(out_fac_a), fa);
    chk(int'(out_fac_b) == fb, "R4 fac_b", int'(out_fac_b), fb);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 release", int'(in_ready), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    run(15, 7, 0, 1'b0);   // R3 R4 R7: period 4, factors 3 and 5
    run(15, 10, 2, 1'b0);  // R5: period 1
    run(15, 14, 0, 1'b1);  // R6: factors 1 and 15
    run(15, 9, 3, 1'b0);   // R7: one nontrivial factor
    run(15, 4, 0, 1'b1);
    run(15, 11, 0, 1'b0);
    run(15, 1, 2, 1'b0);   // R2
    run(15, 15, 0, 1'b0);  // R2
    run(15, 0, 0, 1'b0);   // R2
    run(9, 3, 0, 1'b0);    // R8: powers fall to zero
    run(21, 2, 4, 1'b1);   // period 6, factors 7 and 3
    run(35, 6, 0, 1'b0);
    run(77, 2, 0, 1'b0);
    run(91, 3, 1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule